// File: doc/BRIEF.md
# Multiplexed Eight-Digit Seven-Segment Scanner

This block drives a time-multiplexed LED display of eight decimal digits. It takes eight latched BCD digits and scans them one at a time from the most significant digit down to the least significant. For each scanned digit it produces a one-hot digit strobe, seven segment lines, a decimal point and the raw BCD nibble of that digit. Every digit slot opens with a short dark gap in which no strobe is on and the BCD nibble has already switched. External logic can therefore capture the nibble on the rising edge of the strobe.

The decimal point position comes from a lookup on the measurement mode, the range, a slow-timebase flag and an external-range flag. An external point position can be used instead: a digit strobe is looped back to an input, and the point is taken from whichever strobe comes back. Zeros above the point are suppressed, and this suppression is cancelled when the counter has overflowed. Overflow also lights the point of the top digit. The block also has a lamp test and a display-off control, and one parameter flips the strobe and segment polarity to suit common-anode or common-cathode displays.

Top module: `led_scan`

## Requirements
- R1: The digits are scanned from the top digit (index NDIG-1) down to index 0, then the scan starts again. Each slot is BLANK_CYC dark cycles followed by DRIVE_CYC drive cycles. During the drive cycles exactly one strobe is on. Two different strobes are never on in consecutive cycles.
- R2: `bcd_o` carries the nibble of the digit being scanned for the whole slot, including its dark gap. It is unaffected by zero suppression, lamp test and display off.
- R3: The segment bits are bit0=a through bit6=g. The codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F (hex). Nibbles 10 to 15 drive no segment.
- R4: Digit i is dark when it and every digit above it are zero and i is above the point digit. The point digit and all digits below it are always shown. When there is no point, digit 0 is always shown.
- R5: While `ovf_i` is high, no digit is suppressed and the point of the top digit is lit.
- R6: The point digit index depends on the mode code (0 freq, 1 period, 2 ratio, 3 interval, 4 unit count, 5 oscillator test) and the range r (0..3). Freq and oscillator use r+1. Period and interval use r+1, or r when `slow_tb_i` is set. Ratio uses r. Unit count uses 0. When `range_ext_i` is set there is no point.
- R7: With `xdp_en_i` set, the point is lit on any driven digit while `xdp_i` is active. Suppression then uses the digit at which `xdp_i` was last seen active during a drive phase. That digit is 0 after reset.
- R8: Lamp test lights all seven segments and the point on every driven digit.
- R9: Display off keeps every strobe, segment and point dark, and it overrides lamp test. BCD scanning continues.
- R10: With ACTIVE_LOW=1, strobes, segments, point and `xdp_i` are inverted. `bcd_o` is not.
- R11: During reset, the top digit's nibble is on `bcd_o` and all strobes, segments and the point are dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digits_i | input | 4*NDIG | Latched BCD digits, digit i at bits 4i+3:4i |
| func_i | input | 3 | Measurement mode code |
| range_i | input | 2 | Range code 0..3 |
| range_ext_i | input | 1 | External range selected (no point) |
| slow_tb_i | input | 1 | Slow timebase; shifts the point right in period and interval |
| ovf_i | input | 1 | Counter overflow |
| test_i | input | 1 | Lamp test |
| off_i | input | 1 | Display off |
| xdp_en_i | input | 1 | Use the looped-back point input |
| xdp_i | input | 1 | Looped-back digit strobe for the point |
| dig_o | output | NDIG | Digit strobes |
| seg_o | output | 7 | Segments a..g |
| dp_o | output | 1 | Decimal point |
| bcd_o | output | 4 | Nibble of the scanned digit |

## Verification
The bench goes after the gap between slots, where a design that switched the nibble together with the strobe would hand external latches the previous digit. It also targets suppression around the point, where an off-by-one would either blank the point digit or show a leading zero. Overflow must cancel suppression even when all digits are zero. The point must shift for the slow timebase only in period and interval modes, and a design that used the wrong index would misplace the point. Display off must win over lamp test. Looped-back points must work at every allowed digit, where a design that took the position from the current frame rather than the last one would show suppression errors on the upper digits.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    typedef enum logic [2:0] {
        FN_FREQ   = 3'd0,
        FN_PERIOD = 3'd1,
        FN_RATIO  = 3'd2,
        FN_TINT   = 3'd3,
        FN_UNIT   = 3'd4,
        FN_OSC    = 3'd5
    } func_e;

    typedef logic [3:0] dpos_t;

    typedef struct packed {
        logic  valid;
        dpos_t pos;
    } dp_sel_t;

    localparam logic [6:0] SEG_ALL = 7'h7F;

    // segment pattern, bit0 = a ... bit6 = g
    function automatic logic [6:0] seg_encode(input logic [3:0] nib);
        logic [6:0] s;
        case (nib)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    function automatic dp_sel_t dp_lookup(input func_e f, input logic [1:0] r,
                                          input logic slow, input logic rext);
        dp_sel_t s;
        dpos_t   rr;
        rr      = {2'b00, r};
        s.valid = !rext;
        case (f)
            FN_FREQ, FN_OSC:   s.pos = rr + 4'd1;
            FN_PERIOD, FN_TINT: s.pos = rr + {3'b000, !slow};
            FN_RATIO:          s.pos = rr;
            default:           s.pos = 4'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/led_scan_timer.sv
module led_scan_timer #(
    parameter int NDIG      = 8,
    parameter int DRIVE_CYC = 122,
    parameter int BLANK_CYC = 3,
    localparam int SLOT = DRIVE_CYC + BLANK_CYC,
    localparam int CW   = $clog2(SLOT + 1),
    localparam int IW   = $clog2(NDIG)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] idx_o,
    output logic          drive_o
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            idx_o <= IW'(NDIG - 1);
        end else if (cnt == CW'(SLOT - 1)) begin
            cnt   <= '0;
            idx_o <= (idx_o == '0) ? IW'(NDIG - 1) : idx_o - 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign drive_o = (cnt >= CW'(BLANK_CYC));
endmodule

// File: rtl/led_scan_lzb.sv
module led_scan_lzb
    import led_scan_pkg::*;
#(
    parameter int NDIG = 8
) (
    input  logic [4*NDIG-1:0] digits_i,
    input  dpos_t             pos_i,
    input  logic              ovf_i,
    output logic [NDIG-1:0]   dark_o
);
    logic [NDIG:0] zero_top;

    assign zero_top[NDIG] = 1'b1;

    genvar g;
    generate
        for (g = NDIG - 1; g >= 0; g--) begin : g_dig
            assign zero_top[g] = zero_top[g+1] && (digits_i[4*g +: 4] == 4'd0);
            assign dark_o[g]   = !ovf_i && zero_top[g] && (32'(g) > 32'(pos_i));
        end
    endgenerate
endmodule

// File: rtl/led_scan.sv
module led_scan
    import led_scan_pkg::*;
#(
    parameter int NDIG       = 8,
    parameter int DRIVE_CYC  = 122,
    parameter int BLANK_CYC  = 3,
    parameter bit ACTIVE_LOW = 1'b0,
    localparam int IW = $clog2(NDIG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4*NDIG-1:0] digits_i,
    input  logic [2:0]        func_i,
    input  logic [1:0]        range_i,
    input  logic              range_ext_i,
    input  logic              slow_tb_i,
    input  logic              ovf_i,
    input  logic              test_i,
    input  logic              off_i,
    input  logic              xdp_en_i,
    input  logic              xdp_i,
    output logic [NDIG-1:0]   dig_o,
    output logic [6:0]        seg_o,
    output logic              dp_o,
    output logic [3:0]        bcd_o
);
    logic [IW-1:0]   idx;
    logic            drive;
    logic [NDIG-1:0] dark;
    logic [IW-1:0]   ext_pos;
    dp_sel_t         tbl_sel;
    dpos_t           lz_pos;
    logic            xdp_t;
    logic [3:0]      cur_nib;
    logic [NDIG-1:0] dig_t;
    logic [6:0]      seg_t;
    logic            dp_t;

    led_scan_timer #(
        .NDIG(NDIG), .DRIVE_CYC(DRIVE_CYC), .BLANK_CYC(BLANK_CYC)
    ) u_timer (
        .clk(clk), .rst(rst), .idx_o(idx), .drive_o(drive)
    );

    assign xdp_t   = xdp_i ^ ACTIVE_LOW;
    assign tbl_sel = dp_lookup(func_e'(func_i), range_i, slow_tb_i, range_ext_i);
    assign lz_pos  = xdp_en_i ? dpos_t'(ext_pos) : (tbl_sel.valid ? tbl_sel.pos : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_pos <= '0;
        end else if (drive && xdp_en_i && xdp_t) begin
            ext_pos <= idx;
        end
    end

    led_scan_lzb #(.NDIG(NDIG)) u_lzb (
        .digits_i(digits_i), .pos_i(lz_pos), .ovf_i(ovf_i), .dark_o(dark)
    );

    assign cur_nib = digits_i[4*idx +: 4];

    always_comb begin
        dig_t = '0;
        seg_t = '0;
        dp_t  = 1'b0;
        if (!off_i && drive) begin
            dig_t[idx] = 1'b1;
            if (test_i) begin
                seg_t = SEG_ALL;
                dp_t  = 1'b1;
            end else begin
                seg_t = dark[idx] ? 7'h00 : seg_encode(cur_nib);
                if (xdp_en_i) dp_t = xdp_t;
                else          dp_t = tbl_sel.valid && (dpos_t'(idx) == tbl_sel.pos);
                if (ovf_i && idx == IW'(NDIG - 1)) dp_t = 1'b1;
            end
        end
    end

    assign dig_o = dig_t ^ {NDIG{ACTIVE_LOW}};
    assign seg_o = seg_t ^ {7{ACTIVE_LOW}};
    assign dp_o  = dp_t ^ ACTIVE_LOW;
    assign bcd_o = cur_nib;
endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
    parameter int NDIG       = 8,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic [NDIG-1:0] dig_o,
    input logic [6:0]      seg_o,
    input logic            dp_o,
    input logic [3:0]      bcd_o,
    input logic            off_i,
    input logic            test_i
);
    logic [NDIG-1:0] dig_t;
    logic [6:0]      seg_t;
    logic            dp_t;

    assign dig_t = dig_o ^ {NDIG{ACTIVE_LOW}};
    assign seg_t = seg_o ^ {7{ACTIVE_LOW}};
    assign dp_t  = dp_o ^ ACTIVE_LOW;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dig_t)); // R1

    AST_NO_ADJACENT_STROBES: assert property (@(posedge clk) disable iff (rst)
        ((dig_t != '0) && ($past(dig_t) != '0)) |-> (dig_t == $past(dig_t))); // R1

    AST_BCD_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(|dig_t) |-> $stable(bcd_o)); // R2

    AST_OFF_DARK: assert property (@(posedge clk) disable iff (rst)
        off_i |-> (dig_t == '0 && seg_t == 7'h00 && !dp_t)); // R9

    AST_TEST_LIT: assert property (@(posedge clk) disable iff (rst)
        (test_i && !off_i && (dig_t != '0)) |-> (seg_t == 7'h7F && dp_t)); // R8
endmodule

bind led_scan led_scan_chk #(.NDIG(NDIG), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk(clk), .rst(rst), .dig_o(dig_o), .seg_o(seg_o), .dp_o(dp_o),
    .bcd_o(bcd_o), .off_i(off_i), .test_i(test_i)
);

// File: tb/led_scan_bench.sv
module led_scan_bench;
    localparam int NDIG  = 8;
    localparam int DRV   = 10;
    localparam int BLK   = 2;
    localparam int SLOT  = DRV + BLK;
    localparam int FRAME = NDIG * SLOT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] digits = '0;
    logic [2:0]  func = '0;
    logic [1:0]  rng = '0;
    logic        rext = 1'b0, slow = 1'b0, ovf = 1'b0, test = 1'b0, off = 1'b0;
    logic        xen = 1'b0;
    int          xsel = -1;
    logic        xdp, xdp_n;
    logic [7:0]  dig, dig_n;
    logic [6:0]  seg, seg_n;
    logic        dp, dp_n;
    logic [3:0]  bcd, bcd_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign xdp   = (xsel >= 0) ? dig[xsel]   : 1'b0;
    assign xdp_n = (xsel >= 0) ? dig_n[xsel] : 1'b1;

    led_scan #(.NDIG(NDIG), .DRIVE_CYC(DRV), .BLANK_CYC(BLK), .ACTIVE_LOW(1'b0)) u_led_scan (
        .clk(clk), .rst(rst), .digits_i(digits), .func_i(func), .range_i(rng),
        .range_ext_i(rext), .slow_tb_i(slow), .ovf_i(ovf), .test_i(test), .off_i(off),
        .xdp_en_i(xen), .xdp_i(xdp), .dig_o(dig), .seg_o(seg), .dp_o(dp), .bcd_o(bcd));

    led_scan #(.NDIG(NDIG), .DRIVE_CYC(DRV), .BLANK_CYC(BLK), .ACTIVE_LOW(1'b1)) u_led_scan_inv (
        .clk(clk), .rst(rst), .digits_i(digits), .func_i(func), .range_i(rng),
        .range_ext_i(rext), .slow_tb_i(slow), .ovf_i(ovf), .test_i(test), .off_i(off),
        .xdp_en_i(xen), .xdp_i(xdp_n), .dig_o(dig_n), .seg_o(seg_n), .dp_o(dp_n), .bcd_o(bcd_n));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] seg_ref(input int n);
        case (n)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [31:0] pat(input int k);
        case (k % 5)
            0: return 32'h0000_0305;
            1: return 32'h0000_0000;
            2: return 32'h0012_0400;
            3: return 32'h9876_5432;
            default: return 32'h0000_00AB;
        endcase
    endfunction

    task automatic run_cfg(input logic [31:0] d, input int f, input int r, input bit re,
                           input bit sl, input bit ov, input bit ts, input bit of,
                           input int xs);
        int pos;
        bit pv;
        @(negedge clk);
        rst = 1'b1;
        digits = d; func = 3'(f); rng = 2'(r); rext = re; slow = sl;
        ovf = ov; test = ts; off = of; xen = (xs >= 0); xsel = xs;
        // reference point position (R6 / R7)
        pv = !re;
        case (f)
            0, 5: pos = r + 1;
            1, 3: pos = r + 1 - int'(sl);
            2:    pos = r;
            default: pos = 0;
        endcase
        if (!pv) pos = 0;
        if (xs >= 0) pos = xs;
        @(negedge clk);
        #1;
        chk("R11 reset strobes", int'(dig), 0);
        chk("R11 reset segments", int'(seg), 0);
        chk("R11 reset point", int'(dp), 0);
        chk("R11 reset bcd", int'(bcd), int'(d[31:28]));
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int n = 0; n < 2 * FRAME; n++) begin
            if (n >= FRAME) begin
                int  i    = NDIG - 1 - ((n / SLOT) % NDIG);
                bit  act  = (n % SLOT) >= BLK;
                int  nib  = int'((d >> (4 * i)) & 32'hF);
                bit  dark = !ov && ((d >> (4 * i)) == 0) && (i > pos);
                int  edig = (of || !act) ? 0 : (1 << i);
                int  eseg;
                int  edp;
                if (of || !act) eseg = 0;
                else if (ts) eseg = 7'h7F;
                else if (dark) eseg = 0;
                else eseg = int'(seg_ref(nib));
                if (of || !act) edp = 0;
                else if (ts) edp = 1;
                else edp = int'(((xs >= 0) ? (i == xs) : (pv && i == pos)) || (ov && i == 7));
                chk("R1 strobe", int'(dig), edig);
                chk("R2 bcd", int'(bcd), nib);
                chk(ts ? "R8 segments" : (dark ? "R4 suppression" : "R3 segments"),
                    int'(seg), eseg);
                chk(ov ? "R5 point" : ((xs >= 0) ? "R7 point" : "R6 point"), int'(dp), edp);
                if (of) chk("R9 off dark", int'({dig, seg, dp}), 0);
                chk("R10 polarity", int'({dig_n, seg_n, dp_n, bcd_n}),
                    int'({~dig, ~seg, ~dp, bcd}));
            end
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        // R6: every mode, range and timebase, varied digit patterns
        for (int f = 0; f < 6; f++)
            for (int r = 0; r < 4; r++)
                for (int s = 0; s < 2; s++)
                    run_cfg(pat(f * 8 + r * 2 + s), f, r, 1'b0, s[0], 1'b0, 1'b0, 1'b0, -1);
        // R6: external range gives no point
        for (int f = 0; f < 6; f++)
            run_cfg(pat(f), f, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        // R5: overflow cancels suppression, top point lit
        run_cfg(32'h0, 0, 3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -1);
        run_cfg(32'h0000_0305, 2, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, -1);
        // R3: non-decimal codes and all digits
        run_cfg(32'hFEDC_BA98, 4, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        run_cfg(32'h7654_3210, 4, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        // R8, R9: lamp test, off, off over test
        run_cfg(32'h0000_0012, 0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, -1);
        run_cfg(32'h0000_0012, 0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, -1);
        run_cfg(32'h1234_5678, 0, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        // R7: looped-back point on each usable digit
        for (int e = 0; e < 7; e++) begin
            run_cfg(32'h0000_0012, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, e);
            run_cfg(32'h0000_0000, 3, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, e);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule